// File: doc/BRIEF.md
# Zero-Crossing Peak-to-Peak Jitter Meter

This block measures timing jitter on a sampled data waveform. The waveform arrives as one signed, already-filtered sample per clock. The sample grid runs at 62.5 ps per sample, so one 8 ns symbol period (125 MHz symbol rate) spans 128 sample positions. The sample stream and a reference-clock crossing marker share one master clock domain. Because of that, the position of each data crossing can be measured against the most recent reference crossing rather than against a free-running count.

Every sign change in the data waveform is a crossing. Its offset from the last reference marker is taken modulo 128 and read as a signed value in -64..+63, so crossings that fall slightly before a marker do not look like large offsets. Over a measurement run the block keeps the earliest and latest offsets it has seen. When a programmed number of crossings has been counted, it reports the spread between them in sample ticks and a pass flag. The pass limit is below 300 ps, which is 4 ticks or fewer.

A measurement run is started by a one-cycle start pulse. If the waveform stops crossing for 256 consecutive samples, the run ends at once with a sticky no-activity flag, and that flag forces a fail.

Top module: `jitter_spread_meter`

## Requirements
- R1: After reset, running, done, pass and no_activity are 0 and spread is 0.
- R2: A crossing is a difference in sign between the current sample and the previous sample. A sample of exactly zero counts as non-negative, so a step from -1 to 0 is a crossing.
- R3: A crossing's offset is the number of samples since the latest sample that carried ref_mark (that sample itself has offset 0). The offset is taken modulo 128 and read as two's complement in -64..+63, so a crossing 2 samples before a marker has offset -2.
- R4: spread equals the largest minus the smallest offset among the crossings counted in the run, as an unsigned tick count.
- R5: A start pulse clears the spread, the edge count and the no-activity flag, and raises running from the next cycle. A crossing in the start cycle itself is not counted.
- R6: done is high for exactly one cycle, in the cycle after the sample that holds the target-th counted crossing. At the same time running falls. A target of 0 selects the default target, which is 100000 unless overridden by parameter.
- R7: After a run ends, pass is 1 exactly when spread is 4 ticks or fewer and no_activity is 0. pass is 0 while idle or running.
- R8: If 256 consecutive samples of a run contain no crossing, no_activity is set, the run ends with a done pulse and pass is 0. The flag holds until the next start.
- R9: After a run ends, spread, pass and no_activity do not change and no further done pulse occurs until the next start, whatever the waveform does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a measurement run |
| target | input | CNT_W (17) | Number of crossings per run; 0 selects the default |
| ref_mark | input | 1 | High on the sample where the reference clock crosses |
| sample | input | SW (12) | Signed filtered waveform sample |
| running | output | 1 | A run is collecting crossings |
| done | output | 1 | One-cycle pulse when a run ends |
| spread | output | PH_W (7) | Peak-to-peak offset spread in sample ticks |
| pass | output | 1 | Result is within the jitter limit |
| no_activity | output | 1 | Sticky flag: the run saw a crossing-free stretch |

## Verification
The bench builds the block with an 8-bit sample and a default target of 6 crossings, so the zero-target path finishes within a few hundred cycles. The 128-sample period and the 256-sample inactivity limit stay at their real values, which lets the no-activity test time the full window to the cycle. The bench sweeps every pair of earliest and latest offsets from -5..0 to 0..5. That places spreads on both sides of the 4-tick limit and puts crossings on both sides of the period wrap. Each expected spread is computed from the offsets the bench itself placed.

// File: rtl/jsm_pkg.sv
package jsm_pkg;

   // Run control states of the measurement
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_HELD = 2'd2
   } run_state_t;

endpackage

// File: rtl/jsm_phase.sv
// Tracks the sample position relative to the latest reference crossing.
module jsm_phase #(
   parameter int PH_W = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ref_mark,
   output logic signed [PH_W-1:0] offset
);
   logic [PH_W-1:0] phase_q;
   logic [PH_W-1:0] pos_now;

   // The marker sample itself sits at position zero
   assign pos_now = ref_mark ? '0 : phase_q;
   // Reading modulo-period position as two's complement gives the signed offset
   assign offset  = signed'(pos_now);

   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= '0;
      else        phase_q <= pos_now + PH_W'(1);
   end
endmodule

// File: rtl/jsm_xdet.sv
// Flags a sign change between consecutive samples; zero counts as non-negative.
module jsm_xdet #(
   parameter int SW = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [SW-1:0] sample,
   output logic                 hit
);
   logic neg_now;
   logic prev_neg_q;
   logic prev_ok_q;

   assign neg_now = (sample < 0);
   assign hit     = prev_ok_q && (neg_now != prev_neg_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_neg_q <= 1'b0;
         prev_ok_q  <= 1'b0;
      end else begin
         prev_neg_q <= neg_now;
         prev_ok_q  <= 1'b1;
      end
   end
endmodule

// File: rtl/jsm_extent.sv
// Keeps the earliest and latest offsets of a run and their difference.
module jsm_extent #(
   parameter int PH_W = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic                   upd,
   input  logic signed [PH_W-1:0] offset,
   output logic        [PH_W-1:0] spread
);
   logic signed [PH_W-1:0] min_q;
   logic signed [PH_W-1:0] max_q;
   logic                   have_q;

   // True difference lies in 0..2**PH_W-1, so modulo arithmetic is exact
   assign spread = unsigned'(max_q) - unsigned'(min_q);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         min_q  <= '0;
         max_q  <= '0;
         have_q <= 1'b0;
      end else if (upd) begin
         have_q <= 1'b1;
         if (!have_q) begin
            min_q <= offset;
            max_q <= offset;
         end else begin
            if (offset < min_q) min_q <= offset;
            if (offset > max_q) max_q <= offset;
         end
      end
   end
endmodule

// File: rtl/jitter_spread_meter.sv
module jitter_spread_meter #(
   parameter int SW         = 12,
   parameter int PH_W       = 7,
   parameter int CNT_W      = 17,
   parameter int DEF_TARGET = 100000,
   parameter int IDLE_LIMIT = 256,
   parameter int PASS_TICKS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [CNT_W-1:0]     target,
   input  logic                 ref_mark,
   input  logic signed [SW-1:0] sample,
   output logic                 running,
   output logic                 done,
   output logic [PH_W-1:0]      spread,
   output logic                 pass,
   output logic                 no_activity
);
   import jsm_pkg::*;

   localparam int                IDLE_W    = $clog2(IDLE_LIMIT);
   localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_LIMIT - 1);
   localparam logic [CNT_W-1:0]  DEF_GOAL  = CNT_W'(DEF_TARGET);
   localparam logic [PH_W-1:0]   PASS_LIM  = PH_W'(PASS_TICKS);

   // Elaboration-time parameter checks
   generate
      if (SW < 2) begin : g_bad_sw
         $error("jitter_spread_meter: SW must be at least 2");
      end
      if (PH_W < 2) begin : g_bad_ph
         $error("jitter_spread_meter: PH_W must be at least 2");
      end
      if (DEF_TARGET < 1 || DEF_TARGET >= (2 ** CNT_W)) begin : g_bad_goal
         $error("jitter_spread_meter: DEF_TARGET must fit CNT_W and be nonzero");
      end
      if (IDLE_LIMIT < 2 || (IDLE_LIMIT & (IDLE_LIMIT - 1)) != 0) begin : g_bad_idle
         $error("jitter_spread_meter: IDLE_LIMIT must be a power of two of at least 2");
      end
      if (PASS_TICKS < 0 || PASS_TICKS >= (2 ** PH_W)) begin : g_bad_pass
         $error("jitter_spread_meter: PASS_TICKS out of range");
      end
   endgenerate

   logic signed [PH_W-1:0] offset;
   logic                   hit;
   run_state_t             state_q;
   logic [CNT_W-1:0]       cnt_q;
   logic [CNT_W-1:0]       cnt_inc;
   logic [CNT_W-1:0]       goal;
   logic [IDLE_W-1:0]      idle_q;
   logic                   done_q;
   logic                   noact_q;
   logic                   upd;

   jsm_phase #(.PH_W(PH_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_mark (ref_mark),
      .offset   (offset)
   );

   jsm_xdet #(.SW(SW)) u_xdet (
      .clk    (clk),
      .rst_n  (rst_n),
      .sample (sample),
      .hit    (hit)
   );

   assign upd = (state_q == ST_RUN) && hit && !start;

   jsm_extent #(.PH_W(PH_W)) u_extent (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (start),
      .upd    (upd),
      .offset (offset),
      .spread (spread)
   );

   assign goal    = (target == '0) ? DEF_GOAL : target;
   assign cnt_inc = cnt_q + CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         idle_q  <= '0;
         done_q  <= 1'b0;
         noact_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            idle_q  <= '0;
            noact_q <= 1'b0;
         end else if (state_q == ST_RUN) begin
            if (hit) begin
               idle_q <= '0;
               cnt_q  <= cnt_inc;
               if (cnt_inc == goal) begin
                  state_q <= ST_HELD;
                  done_q  <= 1'b1;
               end
            end else if (idle_q == IDLE_LAST) begin
               noact_q <= 1'b1;
               state_q <= ST_HELD;
               done_q  <= 1'b1;
            end else begin
               idle_q <= idle_q + IDLE_W'(1);
            end
         end
      end
   end

   assign running     = (state_q == ST_RUN);
   assign done        = done_q;
   assign no_activity = noact_q;
   assign pass        = (state_q == ST_HELD) && !noact_q && (spread <= PASS_LIM);
endmodule

// File: rtl/jsm_checks.sv
module jsm_checks #(
   parameter int PH_W = 7
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            running,
   input logic            done,
   input logic [PH_W-1:0] spread,
   input logic            pass,
   input logic            no_activity
);
   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_ends_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !running);

   assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (running && spread == '0 && !no_activity));

   assert_pass_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      no_activity |-> !pass);

   assert_noact_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (no_activity && !start) |=> no_activity);

   assert_hold_results_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !start) |=> ($stable(spread) && $stable(pass) && !done));

   assert_pass_only_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> !pass);
endmodule

bind jitter_spread_meter jsm_checks #(.PH_W(PH_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .running     (running),
   .done        (done),
   .spread      (spread),
   .pass        (pass),
   .no_activity (no_activity)
);

// File: tb/sim_jitter_spread_meter.sv
module sim_jitter_spread_meter;
   localparam int SW    = 8;
   localparam int PH_W  = 7;
   localparam int CNT_W = 17;
   localparam int DEFT  = 6;
   localparam int IDLE  = 256;
   localparam int PER   = 128;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start = 1'b0;
   logic [CNT_W-1:0]     target = '0;
   logic                 ref_mark = 1'b0;
   logic signed [SW-1:0] sample = '0;
   logic                 running, done, pass, no_activity;
   logic [PH_W-1:0]      spread;

   always #4 clk = ~clk;

   jitter_spread_meter #(
      .SW(SW), .PH_W(PH_W), .CNT_W(CNT_W), .DEF_TARGET(DEFT),
      .IDLE_LIMIT(IDLE), .PASS_TICKS(4)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .target(target),
      .ref_mark(ref_mark), .sample(sample), .running(running), .done(done),
      .spread(spread), .pass(pass), .no_activity(no_activity)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // Waveform generator state
   int t = 0;
   int k = 1;
   int lo_g = 0;
   int hi_g = 0;
   int sched_d = 0;
   int next_tog = PER;
   int cur_d = 0;
   bit lvl = 0;
   bit xing = 0;
   bit freeze = 0;
   logic signed [SW-1:0] pos_lvl = 8'sd40;
   logic signed [SW-1:0] neg_lvl = -8'sd30;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Drive one sample, let one rising edge pass, return at the following falling edge
   task automatic tick(input bit st);
      ref_mark = (t % PER == 0);
      xing = 0;
      if (!freeze && t == next_tog) begin
         lvl = !lvl;
         xing = 1;
         cur_d = sched_d;
         k++;
         sched_d = lo_g + (k % (hi_g - lo_g + 1));
         next_tog = k * PER + sched_d;
      end
      sample = lvl ? pos_lvl : neg_lvl;
      start = st;
      @(posedge clk);
      t++;
      @(negedge clk);
   endtask

   task automatic resync();
      k = t / PER + 1;
      sched_d = lo_g + (k % (hi_g - lo_g + 1));
      next_tog = k * PER + sched_d;
   endtask

   // One measurement run; expected spread from the offsets actually placed
   task automatic run(input int lo, input int hi, input int tgt, input int expn, input string tag);
      int cnt = 0;
      int mn = 1000;
      int mx = -1000;
      bit got = 0;
      int guard = 0;
      lo_g = lo;
      hi_g = hi;
      target = CNT_W'(tgt);
      tick(1);
      while (!got && guard < 20000) begin
         tick(0);
         guard++;
         if (xing && cnt < expn) begin
            cnt++;
            if (cur_d < mn) mn = cur_d;
            if (cur_d > mx) mx = cur_d;
         end
         if (done) begin
            got = 1;
            // R6: done follows the target-th counted crossing directly
            chk(xing && cnt == expn, {"R6 done timing ", tag}, cnt, expn);
         end
      end
      chk(got, {"R6 done seen ", tag}, got, 1);
      chk(running == 0, {"R6 running falls ", tag}, running, 0);
      // R3/R4: spread from signed offsets, including those wrapped before a marker
      chk(int'(spread) == mx - mn, {"R4 spread ", tag}, spread, mx - mn);
      // R7: pass limit of 4 ticks
      chk(pass == ((mx - mn) <= 4), {"R7 pass ", tag}, pass, ((mx - mn) <= 4));
      tick(0);
      chk(done == 0, {"R6 single pulse ", tag}, done, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      repeat (4) tick(0);
      // R1: reset state
      chk(running == 0 && done == 0 && pass == 0 && no_activity == 0 && spread == 0,
          "R1 reset state", {running, done, pass, no_activity}, 0);
      rst_n = 1;
      resync();
      repeat (3) tick(0);
      chk(running == 0 && pass == 0, "R1 idle after reset", {running, pass}, 0);

      // R2 R3 R4 R6 R7: sweep of earliest and latest offsets
      for (int lo = -5; lo <= 0; lo++) begin
         for (int hi = 0; hi <= 5; hi++) begin
            run(lo, hi, 12, 12, "sweep");
         end
      end

      // R3: large offsets on both sides of the period wrap
      run(-20, 17, 40, 40, "wide");

      // R2: zero counts as non-negative (-1 to 0 is a crossing)
      pos_lvl = 8'sd0;
      neg_lvl = -8'sd1;
      run(-2, 2, 10, 10, "R2 zero level");
      pos_lvl = 8'sd40;
      neg_lvl = -8'sd30;

      // R6: target zero selects default of DEFT crossings
      run(0, 3, 0, DEFT, "default target");

      // R9: results hold after a run while the waveform keeps moving
      begin
         logic [PH_W-1:0] sp0;
         bit p0;
         bit extra;
         sp0 = spread;
         p0 = pass;
         extra = 0;
         lo_g = -9;
         hi_g = 9;
         repeat (400) begin
            tick(0);
            if (done || spread != sp0 || pass != p0 || no_activity) extra = 1;
         end
         chk(!extra, "R9 results held", spread, sp0);
      end

      // R8: no crossing for the whole window
      begin
         int n = 0;
         freeze = 1;
         target = CNT_W'(5);
         tick(1);
         chk(running == 1, "R5 running after start", running, 1);
         while (!done && n < 2000) begin
            tick(0);
            n++;
         end
         chk(n == IDLE, "R8 timeout window", n, IDLE);
         chk(no_activity == 1 && pass == 0, "R8 flag and fail", {no_activity, pass}, 2);
         repeat (20) tick(0);
         chk(no_activity == 1, "R8 sticky", no_activity, 1);
         freeze = 0;
         lo_g = 0;
         hi_g = 2;
         resync();
      end

      // R5: start clears the flag and a fresh run measures normally
      target = CNT_W'(6);
      tick(1);
      chk(no_activity == 0 && spread == 0 && running == 1, "R5 start clears",
          {no_activity, running}, 1);
      run(-1, 1, 6, 6, "after timeout");

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule